// File: doc/BRIEF.md
# Register Sequence Command Executor

This block works through a ring of fixed-size command slots held in a word-addressable command store. Each slot is one header word followed by up to fifteen payload words. The block also masters a simple 32-bit register bus that uses a request/ready handshake. Whenever its read pointer differs from the host's write pointer, it copies the next slot into a local slot register and decodes the header. It then runs that command's register accesses on the bus.

Four command kinds are understood:

- **Read-modify-write** applies several independent address/mask/value entries.
- **Field update** reads one register at most once, then writes a chain of masked updates from a held shadow copy. This keeps toggling bits and auto-incrementing registers correct.
- **Burst write** writes a list of values, in order, to one address.
- **Register wait** polls a masked field until it equals an expected value, or until a timeout counted in microsecond ticks runs out.

When a slot is finished, the block raises a one-cycle done pulse together with a result code and a clamp flag. It then advances its read pointer around the ring. Moving the write pointer belongs to the host.

Top module: `regseq_exec`

## Requirements
- R1: The header word holds the command kind in bits 7:0 and the payload byte count in bits 29:24. Kind 1 is read-modify-write, 2 is field update, 3 is burst write and 4 is register wait. Any other kind causes no bus transfer and finishes with result code 2.
- R2: Read-modify-write runs floor(bytes/12) entries, in order. Entry i takes its address, mask and value from payload words 1+3i, 2+3i and 3+3i. Each entry reads the address, then writes (old AND NOT mask) OR (value AND mask).
- R3: A read-modify-write entry whose mask is all ones issues no read and writes the value directly.
- R4: Field update uses the address in word 1 and floor((bytes-4)/8) mask/value pairs, pair i taken from words 2+2i and 3+2i. It issues one read before the first pair. Each pair then merges into a held shadow value and writes that shadow, with no further reads.
- R5: When the first field-update mask is all ones, no read is issued at all.
- R6: Burst write sends floor((bytes-4)/4) values, taken from words 2 onward, to the address in word 1, in word order.
- R7: Register wait reads the address in word 1 until (data AND word 2) equals (word 3 AND word 2), then finishes with result code 0. Successive polls are separated by at least poll_gap+1 clock cycles, and a poll_gap of 0 acts as 1.
- R8: If a wait poll mismatches after at least word-4 microsecond ticks have been counted since the command started, the command finishes with result code 1 and issues no further polls.
- R9: A payload byte count above 60 is handled as 60. The clamped output is high together with that slot's done pulse.
- R10: After each slot, done pulses for exactly one cycle and rd_ptr advances by one, modulo 128. While rd_ptr equals wr_ptr the block issues no bus request. A count of zero finishes with result code 0 and no bus transfer.
- R11: Value bits outside a mask never reach the written data.
- R12: A bus request keeps its address, direction and write data unchanged until reg_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ptr | input | 7 | Host write pointer: index of the next slot the host will fill |
| rd_ptr | output | 7 | Index of the next slot to execute |
| cbuf_addr | output | 11 | Command store word address {slot, word} |
| cbuf_rdata | input | 32 | Command store data, combinational from cbuf_addr |
| reg_req | output | 1 | Bus request strobe |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 32 | Bus address |
| reg_wdata | output | 32 | Bus write data |
| reg_rdata | input | 32 | Bus read data, valid with reg_ready |
| reg_ready | input | 1 | Transfer completes at a clock edge where reg_req and reg_ready are both high |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| poll_gap | input | 8 | Idle cycles between wait polls |
| done | output | 1 | One-cycle pulse when a slot finishes |
| status | output | 2 | Result: 0 ok, 1 timeout, 2 unknown kind |
| clamped | output | 1 | Payload byte count of the finished slot exceeded 60 |

## Verification
The bench targets the read suppression rules:

- An all-ones mask in a read-modify-write entry or at the head of a field-update chain must produce no read. A design that reads anyway shows an extra transfer.
- A design that re-reads between field-update pairs emits reads the model never expects.
- A design that merges from the live register instead of the shadow writes the wrong data.

Values carry bits outside their masks, so a missing AND in the merge shows up as a wrong write value.

Oversized byte counts, zero counts and unknown kinds test the decode arithmetic at its edges. The poll spacing and timeout are checked under a poll_gap of zero. A run of slots across the end of the ring checks the pointer wrap.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

    localparam int DW          = 32;
    localparam int MAX_PAYLOAD = 60;

    localparam logic [7:0] K_RMW   = 8'd1;
    localparam logic [7:0] K_FLD   = 8'd2;
    localparam logic [7:0] K_BURST = 8'd3;
    localparam logic [7:0] K_WAIT  = 8'd4;

    typedef enum logic [1:0] {
        RS_OK      = 2'd0,
        RS_TIMEOUT = 2'd1,
        RS_BADKIND = 2'd2
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DECODE, ST_STEP, ST_READ, ST_WRITE, ST_GAP, ST_FIN
    } st_e;

    typedef struct packed {
        logic [1:0] spare_hi;
        logic [5:0] nbytes;
        logic [7:0] spare_lo;
        logic [7:0] variant;
        logic [7:0] kind;
    } hdr_t;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] mask;
        logic [DW-1:0] val;
    } op_t;

    function automatic logic [DW-1:0] merge_field(logic [DW-1:0] old_v,
                                                  logic [DW-1:0] mask,
                                                  logic [DW-1:0] val);
        return (old_v & ~mask) | (val & mask);
    endfunction

    function automatic logic known_kind(logic [7:0] kind);
        return (kind == K_RMW) || (kind == K_FLD) || (kind == K_BURST) || (kind == K_WAIT);
    endfunction

    // nb is already limited to MAX_PAYLOAD
    function automatic logic [3:0] step_count(logic [7:0] kind, logic [5:0] nb);
        logic [5:0] tail;
        tail = (nb < 6'd4) ? 6'd0 : nb - 6'd4;
        case (kind)
            K_RMW:   return 4'(nb / 6'd12);
            K_FLD:   return 4'(tail / 6'd8);
            K_BURST: return 4'(tail / 6'd4);
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/regseq_slot_fetch.sv
module regseq_slot_fetch
    import regseq_pkg::*;
#(
    parameter int SLOT_WORDS = 16,
    parameter int PTR_W      = 7,
    localparam int WRD_W     = $clog2(SLOT_WORDS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic [PTR_W-1:0]                 slot,
    input  logic [DW-1:0]                    cb_rdata,
    output logic [PTR_W+WRD_W-1:0]           cb_addr,
    output logic                             loaded,
    output logic [SLOT_WORDS-1:0][DW-1:0]    words
);
    logic             busy;
    logic [WRD_W-1:0] wcnt;

    assign cb_addr = {slot, wcnt};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            wcnt   <= '0;
            loaded <= 1'b0;
            words  <= '0;
        end else begin
            loaded <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                wcnt <= '0;
            end else if (busy) begin
                words[wcnt] <= cb_rdata;
                wcnt        <= wcnt + 1'b1;
                if (wcnt == WRD_W'(SLOT_WORDS - 1)) begin
                    busy   <= 1'b0;
                    loaded <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/regseq_poll_timer.sv
module regseq_poll_timer
    import regseq_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             us_tick,
    input  logic             gap_load,
    input  logic [GAP_W-1:0] gap_len,
    output logic [DW-1:0]    elapsed,
    output logic             gap_busy
);
    logic [GAP_W-1:0] gcnt;

    assign gap_busy = (gcnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
            gcnt    <= '0;
        end else begin
            if (clear)
                elapsed <= '0;
            else if (us_tick && (elapsed != '1))
                elapsed <= elapsed + 1'b1;

            if (gap_load)
                gcnt <= (gap_len == '0) ? GAP_W'(1) : gap_len;
            else if (gap_busy)
                gcnt <= gcnt - 1'b1;
        end
    end
endmodule

// File: rtl/regseq_exec.sv
module regseq_exec
    import regseq_pkg::*;
#(
    parameter int SLOTS      = 128,
    parameter int SLOT_WORDS = 16,
    parameter int GAP_W      = 8,
    localparam int PTR_W     = $clog2(SLOTS),
    localparam int WRD_W     = $clog2(SLOT_WORDS),
    localparam int CA_W      = PTR_W + WRD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CA_W-1:0]  cbuf_addr,
    input  logic [DW-1:0]    cbuf_rdata,
    output logic             reg_req,
    output logic             reg_we,
    output logic [DW-1:0]    reg_addr,
    output logic [DW-1:0]    reg_wdata,
    input  logic [DW-1:0]    reg_rdata,
    input  logic             reg_ready,
    input  logic             us_tick,
    input  logic [GAP_W-1:0] poll_gap,
    output logic             done,
    output logic [1:0]       status,
    output logic             clamped
);
    st_e                          state;
    logic [SLOT_WORDS-1:0][DW-1:0] words;
    logic                         fetch_start, loaded;
    logic [7:0]                   kind;
    logic [3:0]                   cnt, idx;
    logic [DW-1:0]                shadow, elapsed;
    res_e                         res;
    logic                         clamp_r, gap_busy, gap_load, tmr_clear;
    op_t                          op;
    hdr_t                         hdr;
    logic [5:0]                   nb_lim;
    logic                         poll_hit, poll_expired, need_read;

    regseq_slot_fetch #(.SLOT_WORDS(SLOT_WORDS), .PTR_W(PTR_W)) u_fetch (
        .clk(clk), .rst(rst), .start(fetch_start), .slot(rd_ptr),
        .cb_rdata(cbuf_rdata), .cb_addr(cbuf_addr), .loaded(loaded), .words(words)
    );

    regseq_poll_timer #(.GAP_W(GAP_W)) u_timer (
        .clk(clk), .rst(rst), .clear(tmr_clear), .us_tick(us_tick),
        .gap_load(gap_load), .gap_len(poll_gap), .elapsed(elapsed), .gap_busy(gap_busy)
    );

    // operand selection for the current step
    always_comb begin
        logic [4:0] base;
        op = '0;
        case (kind)
            K_RMW: begin
                base    = 5'd1 + 5'd3 * {1'b0, idx};
                op.addr = words[base[WRD_W-1:0]];
                op.mask = words[WRD_W'(base + 5'd1)];
                op.val  = words[WRD_W'(base + 5'd2)];
            end
            K_FLD: begin
                base    = 5'd2 + {idx, 1'b0};
                op.addr = words[1];
                op.mask = words[base[WRD_W-1:0]];
                op.val  = words[WRD_W'(base + 5'd1)];
            end
            K_BURST: begin
                base    = 5'd2 + {1'b0, idx};
                op.addr = words[1];
                op.mask = '1;
                op.val  = words[base[WRD_W-1:0]];
            end
            default: begin
                base    = 5'd0;
                op.addr = words[1];
                op.mask = words[2];
                op.val  = words[3];
            end
        endcase
    end

    always_comb begin
        hdr          = hdr_t'(words[0]);
        nb_lim       = (hdr.nbytes > 6'(MAX_PAYLOAD)) ? 6'(MAX_PAYLOAD) : hdr.nbytes;
        poll_hit     = ((reg_rdata ^ op.val) & op.mask) == '0;
        poll_expired = elapsed >= words[4];
        need_read    = (op.mask != '1) &&
                       ((kind == K_RMW) || ((kind == K_FLD) && (idx == 4'd0)));
        fetch_start  = (state == ST_IDLE) && (rd_ptr != wr_ptr);
        tmr_clear    = (state == ST_DECODE);
        gap_load     = (state == ST_READ) && reg_ready && (kind == K_WAIT) &&
                       !poll_hit && !poll_expired;
        reg_req      = (state == ST_READ) || (state == ST_WRITE);
        reg_we       = (state == ST_WRITE);
        reg_addr     = op.addr;
        reg_wdata    = (state == ST_WRITE) ? merge_field(shadow, op.mask, op.val) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rd_ptr  <= '0;
            kind    <= '0;
            cnt     <= '0;
            idx     <= '0;
            shadow  <= '0;
            res     <= RS_OK;
            clamp_r <= 1'b0;
            done    <= 1'b0;
            status  <= 2'd0;
            clamped <= 1'b0;
        end else begin
            done    <= 1'b0;
            clamped <= 1'b0;
            case (state)
                ST_IDLE:   if (fetch_start) state <= ST_FETCH;
                ST_FETCH:  if (loaded) state <= ST_DECODE;
                ST_DECODE: begin
                    kind    <= hdr.kind;
                    cnt     <= step_count(hdr.kind, nb_lim);
                    idx     <= '0;
                    clamp_r <= hdr.nbytes > 6'(MAX_PAYLOAD);
                    res     <= known_kind(hdr.kind) ? RS_OK : RS_BADKIND;
                    state   <= known_kind(hdr.kind) ? ST_STEP : ST_FIN;
                end
                ST_STEP: begin
                    if (kind == K_WAIT)   state <= ST_READ;
                    else if (idx == cnt)  state <= ST_FIN;
                    else if (need_read)   state <= ST_READ;
                    else                  state <= ST_WRITE;
                end
                ST_READ: if (reg_ready) begin
                    shadow <= reg_rdata;
                    if (kind != K_WAIT) begin
                        state <= ST_WRITE;
                    end else if (poll_hit) begin
                        state <= ST_FIN;
                    end else if (poll_expired) begin
                        res   <= RS_TIMEOUT;
                        state <= ST_FIN;
                    end else begin
                        state <= ST_GAP;
                    end
                end
                ST_WRITE: if (reg_ready) begin
                    shadow <= reg_wdata;
                    idx    <= idx + 1'b1;
                    state  <= ST_STEP;
                end
                ST_GAP: if (!gap_busy) state <= ST_READ;
                ST_FIN: begin
                    done    <= 1'b1;
                    status  <= res;
                    clamped <= clamp_r;
                    rd_ptr  <= rd_ptr + 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regseq_exec_chk.sv
module regseq_exec_chk #(
    parameter int PTR_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic             reg_req,
    input logic             reg_we,
    input logic [31:0]      reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             reg_ready,
    input logic             done,
    input logic [1:0]       status,
    input logic             clamped
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req && !reg_ready |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> rd_ptr == PTR_W'($past(rd_ptr) + 1'b1));

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> rd_ptr == $past(rd_ptr));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr == wr_ptr) |-> !reg_req);

    // R9
    clamp_tag_chk: assert property (@(posedge clk) disable iff (rst)
        clamped |-> done);

    // R1
    status_code_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> status != 2'd3);
endmodule

bind regseq_exec regseq_exec_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst(rst), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ready(reg_ready), .done(done), .status(status), .clamped(clamped)
);

// File: tb/sim_regseq_exec.sv
module sim_regseq_exec;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;
    localparam logic [31:0] WAIT_REG = 32'h0000_00F0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  wr_ptr = '0;
    logic [6:0]  rd_ptr;
    logic [10:0] cbuf_addr;
    logic [31:0] cbuf_rdata;
    logic        reg_req, reg_we;
    logic [31:0] reg_addr, reg_wdata;
    logic [31:0] reg_rdata = '0;
    logic        reg_ready = 1'b0;
    logic        us_tick = 1'b0;
    logic [7:0]  poll_gap = 8'd2;
    logic        done, clamped;
    logic [1:0]  status;

    logic [31:0] cbuf [2048];
    logic [31:0] sreg [256];
    logic [31:0] mreg [256];
    logic [31:0] w [16];

    typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } xfer_t;
    xfer_t expq[$];

    int    checks = 0, errors = 0, cyc = 0;
    bit    finished = 0;
    bit    wait_mode = 0;
    int    wait_reads = 0, last_poll = -1;
    logic [31:0] wait_val = '0;
    logic [6:0]  exp_rd = '0;
    string cur_req = "R1";

    assign cbuf_rdata = cbuf[cbuf_addr];

    regseq_exec u0 (
        .clk(clk), .rst(rst), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .cbuf_addr(cbuf_addr), .cbuf_rdata(cbuf_rdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_ready(reg_ready), .us_tick(us_tick),
        .poll_gap(poll_gap), .done(done), .status(status), .clamped(clamped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // bus slave and per-clock transfer comparison, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            us_tick   = (cyc % 8 == 0);
            reg_ready = (cyc % 4 != 1);
            if (!rst && reg_req && reg_ready) begin
                if (wait_mode) begin
                    int gmin;
                    gmin = (poll_gap == 0) ? 2 : int'(poll_gap) + 1;
                    check(!reg_we && reg_addr == WAIT_REG, "R7", "poll is read of wait addr", reg_addr, WAIT_REG);
                    if (last_poll >= 0)
                        check(cyc - last_poll >= gmin, "R7", "poll spacing", cyc - last_poll, gmin);
                    last_poll = cyc;
                    reg_rdata = wait_val;
                    wait_val  = wait_val + 1;
                    wait_reads++;
                end else if (expq.size() == 0) begin
                    check(0, cur_req, "unexpected transfer addr", reg_addr, 32'hFFFF_FFFF);
                end else begin
                    xfer_t x;
                    x = expq.pop_front();
                    check(reg_we == x.we, cur_req, "transfer direction", 32'(reg_we), 32'(x.we));
                    check(reg_addr == x.addr, cur_req, "transfer address", reg_addr, x.addr);
                    if (x.we) begin
                        check(reg_wdata == x.data, cur_req, "write data", reg_wdata, x.data);
                        sreg[reg_addr[7:0]] = reg_wdata;
                    end else begin
                        reg_rdata = sreg[reg_addr[7:0]];
                    end
                end
            end
        end
    end

    function automatic logic [31:0] hdr(logic [7:0] kind, logic [5:0] nb);
        return {2'b00, nb, 8'h00, 8'h5A, kind};
    endfunction

    function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] m, logic [31:0] v);
        return (o & ~m) | (v & m);
    endfunction

    task automatic push(bit we, logic [31:0] a, logic [31:0] d);
        xfer_t x;
        x.we = we; x.addr = a; x.data = d;
        expq.push_back(x);
    endtask

    // behavioural model of one slot, builds expected transfers
    task automatic model_slot();
        int nb, n;
        logic [31:0] sh;
        nb = int'(w[0][29:24]);
        if (nb > 60) nb = 60;
        case (w[0][7:0])
            8'd1: begin
                n = nb / 12;
                for (int i = 0; i < n; i++) begin
                    logic [31:0] a, m, v;
                    a = w[1+3*i]; m = w[2+3*i]; v = w[3+3*i];
                    if (m != ONES) push(0, a, 0);
                    mreg[a[7:0]] = mrg(mreg[a[7:0]], m, v);
                    push(1, a, mreg[a[7:0]]);
                end
            end
            8'd2: begin
                n = (nb < 4) ? 0 : (nb - 4) / 8;
                if (n > 0) begin
                    if (w[2] != ONES) push(0, w[1], 0);
                    sh = mreg[w[1][7:0]];
                    for (int i = 0; i < n; i++) begin
                        sh = mrg(sh, w[2+2*i], w[3+2*i]);
                        push(1, w[1], sh);
                    end
                    mreg[w[1][7:0]] = sh;
                end
            end
            8'd3: begin
                n = (nb < 4) ? 0 : (nb - 4) / 4;
                for (int i = 0; i < n; i++) begin
                    push(1, w[1], w[2+i]);
                    mreg[w[1][7:0]] = w[2+i];
                end
            end
            default: ;
        endcase
    endtask

    task automatic issue();
        for (int i = 0; i < 16; i++) cbuf[{wr_ptr, 4'(i)}] = w[i];
        if (!wait_mode) model_slot();
        @(negedge clk);
        wr_ptr = wr_ptr + 1'b1;
    endtask

    task automatic wait_done(logic [1:0] exp_st, bit exp_cl, string req);
        int t;
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(done == 1'b1, req, "done seen", 32'(done), 1);
        exp_rd = exp_rd + 1'b1;
        check(status == exp_st, req, "status", 32'(status), 32'(exp_st));
        check(clamped == exp_cl, "R9", "clamped flag", 32'(clamped), 32'(exp_cl));
        check(rd_ptr == exp_rd, "R10", "rd_ptr advance", 32'(rd_ptr), 32'(exp_rd));
        @(negedge clk);
        check(done == 1'b0, "R10", "done single cycle", 32'(done), 0);
    endtask

    task automatic finish_queue(string req);
        check(expq.size() == 0, req, "all expected transfers seen", expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2048; i++) cbuf[i] = '0;
        for (int i = 0; i < 256; i++) begin
            sreg[i] = 32'hC3A5_0000 + 32'(i * 7);
            mreg[i] = sreg[i];
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !reg_req && rd_ptr == 0, "R10", "reset state", {rd_ptr, 1'b0, done, reg_req}, 0);

        // R2 R3 R11: mixed read-modify-write
        cur_req = "R2";
        for (int i = 0; i < 16; i++) w[i] = '0;
        w[0] = hdr(8'd1, 6'd36);
        w[1] = 32'h10; w[2] = 32'h0000_FF00; w[3] = 32'hFFFF_12FF;
        w[4] = 32'h11; w[5] = ONES;          w[6] = 32'hDEAD_BEEF;
        w[7] = 32'h10; w[8] = 32'hF000_000F; w[9] = 32'h5555_5555;
        issue(); wait_done(2'd0, 0, "R2"); finish_queue("R3");

        // R4 R11: field update with one read and shadowed writes
        cur_req = "R4";
        for (int i = 0; i < 16; i++) w[i] = '0;
        w[0] = hdr(8'd2, 6'd36); w[1] = 32'h20;
        w[2] = 32'h0000_0001; w[3] = 32'hFFFF_FFFF;
        w[4] = 32'h0000_0001; w[5] = 32'h0000_0000;
        w[6] = 32'h0000_00F0; w[7] = 32'h1234_56A0;
        w[8] = 32'hFF00_0000; w[9] = 32'h8800_0000;
        issue(); wait_done(2'd0, 0, "R4"); finish_queue("R4");

        // R5: first mask all ones, no read
        cur_req = "R5";
        for (int i = 0; i < 16; i++) w[i] = '0;
        w[0] = hdr(8'd2, 6'd28); w[1] = 32'h24;
        w[2] = ONES; w[3] = 32'h0F0F_0F0F;
        w[4] = 32'h0000_0003; w[5] = 32'h0000_0000;
        w[6] = 32'h0000_0003; w[7] = 32'h0000_0002;
        issue(); wait_done(2'd0, 0, "R5"); finish_queue("R5");

        // R6: burst write
        cur_req = "R6";
        for (int i = 0; i < 16; i++) w[i] = 32'h7700_0000 + 32'(i);
        w[0] = hdr(8'd3, 6'd24); w[1] = 32'h30;
        issue(); wait_done(2'd0, 0, "R6"); finish_queue("R6");

        // R9: burst byte count 63 clamped to 60 -> 14 values
        cur_req = "R9";
        for (int i = 0; i < 16; i++) w[i] = 32'h9900_0000 + 32'(i * 3);
        w[0] = hdr(8'd3, 6'd63); w[1] = 32'h34;
        issue(); wait_done(2'd0, 1, "R9"); finish_queue("R9");

        // R9: read-modify-write count 63 -> 5 entries
        for (int i = 0; i < 16; i++) w[i] = 32'h0101_0101 * 32'(i);
        w[0] = hdr(8'd1, 6'd63);
        for (int e = 0; e < 5; e++) begin
            w[1+3*e] = 32'h40 + 32'(e);
            w[2+3*e] = (e == 2) ? ONES : 32'h00FF_00FF;
        end
        issue(); wait_done(2'd0, 1, "R9"); finish_queue("R9");

        // R1: unknown kind
        cur_req = "R1";
        for (int i = 0; i < 16; i++) w[i] = 32'h1;
        w[0] = hdr(8'h77, 6'd40);
        issue(); wait_done(2'd2, 0, "R1"); finish_queue("R1");

        // R10: zero count, no transfer
        cur_req = "R10";
        w[0] = hdr(8'd1, 6'd0);
        issue(); wait_done(2'd0, 0, "R10"); finish_queue("R10");

        // R7: wait that matches on sixth poll
        cur_req = "R7";
        wait_mode = 1; wait_reads = 0; last_poll = -1; wait_val = '0; poll_gap = 8'd3;
        for (int i = 0; i < 16; i++) w[i] = '0;
        w[0] = hdr(8'd4, 6'd16); w[1] = WAIT_REG; w[2] = 32'h0000_00FF;
        w[3] = 32'hAB00_0005; w[4] = 32'd1000;
        issue(); wait_done(2'd0, 0, "R7");
        check(wait_reads == 6, "R7", "poll count", wait_reads, 6);

        // R8: wait that times out, gap 0 acts as 1
        cur_req = "R8";
        wait_reads = 0; last_poll = -1; wait_val = '0; poll_gap = 8'd0;
        w[3] = 32'h0000_00EE; w[4] = 32'd4;
        issue(); wait_done(2'd1, 0, "R8");
        check(wait_reads >= 2 && wait_reads < 40, "R8", "poll count before timeout", wait_reads, 2);
        wait_mode = 0;

        // R10: two slots queued back to back
        cur_req = "R10";
        for (int i = 0; i < 16; i++) w[i] = 32'h3300_0000 + 32'(i);
        w[0] = hdr(8'd3, 6'd12); w[1] = 32'h50;
        issue();
        w[0] = hdr(8'd3, 6'd8); w[1] = 32'h51;
        issue();
        wait_done(2'd0, 0, "R10");
        wait_done(2'd0, 0, "R10");
        finish_queue("R10");

        // R10: run across the end of the ring
        cur_req = "R1";
        for (int i = 0; i < 16; i++) w[i] = '0;
        w[0] = hdr(8'h00, 6'd0);
        while (exp_rd != 7'd0) begin
            issue(); wait_done(2'd2, 0, "R1");
        end
        check(rd_ptr == 7'd0, "R10", "ring wrap", 32'(rd_ptr), 0);
        finish_queue("R1");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule